// File: doc/BRIEF.md
# Audio Serial Clock Prescaler

This block turns a fast source clock into the clocks that an audio serial port needs: a master clock for an external converter (optional), a bit clock, and a word-select signal that swaps between the left and right channel. A programmable integer divider and an odd-extension bit set an effective ratio of `2*DIV + ODD` source cycles. That ratio gives even and odd totals alike. An 8-bit divider value below 2 is not legal, and the block replaces it with divider 2, odd 0.

With the master clock on, the divided clock is driven out as the master clock. The bit clock is that master clock divided by 8 for 16-bit channels or by 4 for 32-bit channels, so every frame holds 256 master-clock cycles. With the master clock off, the divided clock is the bit clock itself, and a frame lasts 32 or 64 bit clocks. Word select starts on the left channel (low). It changes on the bit-clock falling edge that ends the 16th or 32nd bit of each channel.

Configuration is taken from the inputs only while `enable` is low and is held for as long as the block runs. Dropping `enable` returns all three outputs to low at the next source edge and rewinds every counter. The phase generator has three states: IDLE, HIGH and LOW. It moves IDLE→HIGH on enable, HIGH→LOW after DIV cycles and LOW→HIGH after DIV+ODD cycles. The bit-clock stage has four states: OFF, PASS, DIV_HI and DIV_LO. It moves OFF→PASS or OFF→DIV_HI on enable and alternates DIV_HI↔DIV_LO on every 4th or 2nd master-clock rise. The word-select stage has two states, LEFT and RIGHT, which alternate at channel ends. Any state goes to its idle state when enable falls.

Top module: `audio_clk_prescaler`

## Requirements
- R1: After reset, and at any time while `enable` is low, `mck_o`, `bck_o` and `ws_o` are all 0.
- R2: While running, the divided clock has a period of `N = 2*DIV + ODD` source cycles. It is high for DIV cycles and then low for DIV+ODD cycles.
- R3: A divider input of 0 or 1 is replaced by divider 2 and odd 0 (N = 4), whatever the odd input holds. The reset configuration is divider 2, odd 0, master clock off, 16-bit channels.
- R4: With the master clock enabled, `mck_o` equals the divided clock. With it disabled, `mck_o` stays 0.
- R5: With the master clock enabled, `bck_o` is high for the first half and low for the second half of each group of 8 (16-bit channels) or 4 (32-bit channels) master-clock periods, and it rises together with `mck_o`.
- R6: With the master clock disabled, `bck_o` equals the divided clock.
- R7: `ws_o` starts at 0 and inverts on the bit-clock falling edge that completes 16 (`ch32_i`=0) or 32 (`ch32_i`=1) bit clocks of the current channel.
- R8: When `enable` is sampled low, all outputs are 0 after that same edge. A later enable restarts from the first phase.
- R9: Changes to `div_i`, `odd_i`, `mck_en_i` or `ch32_i` while `enable` is high have no effect on the outputs until the block has been disabled.
- R10: On the first edge at which `enable` is sampled high, the divided clock goes high. In master-clock mode `bck_o` goes high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; configuration is captured while low |
| div_i | input | 8 | Linear divider value |
| odd_i | input | 1 | Adds one source cycle to the low phase |
| mck_en_i | input | 1 | 1 = drive master clock and derive bit clock from it |
| ch32_i | input | 1 | 0 = 16 bits per channel, 1 = 32 bits per channel |
| mck_o | output | 1 | Master clock |
| bck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, 0 = left channel |

## Verification
Three edges can land on the same source cycle. At a channel boundary, the word-select change coincides with a bit-clock fall. In master-clock mode, that bit-clock fall also coincides with a master-clock rise, because the second stage toggles only on master-clock rising events. The bench provokes these coincidences by running each configuration of a small divider sweep, with odd on and off, both channel lengths and both modes, through two full frames. At every source cycle it compares all three outputs with closed-form values computed from the cycle index, so an edge that lands one cycle early or late is reported at the exact cycle.

// File: rtl/acp_pkg.sv
package acp_pkg;
    localparam int unsigned DIV_W         = 8;
    localparam int unsigned PH_W          = DIV_W + 1;
    localparam int unsigned CH_SHORT      = 16;
    localparam int unsigned CH_LONG       = 32;
    localparam int unsigned MCK_PER_FRAME = 256;
    // master-clock periods per bit-clock half period
    localparam int unsigned HALF_SHORT    = MCK_PER_FRAME / (4 * CH_SHORT);
    localparam int unsigned HALF_LONG     = MCK_PER_FRAME / (4 * CH_LONG);
    localparam int unsigned RC_W          = (HALF_SHORT > 2) ? $clog2(HALF_SHORT) : 1;
    localparam int unsigned BIT_W         = $clog2(CH_LONG);
    localparam int unsigned MIN_DIV       = 2;

    typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} phase_e;
    typedef enum logic [1:0] {BK_OFF, BK_PASS, BK_DIV_HI, BK_DIV_LO} bck_e;
    typedef enum logic {WS_LEFT, WS_RIGHT} ws_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             odd;
        logic             mck_en;
        logic             ch32;
    } acp_cfg_t;

    localparam acp_cfg_t CFG_RESET = '{div: DIV_W'(MIN_DIV), odd: 1'b0, mck_en: 1'b0, ch32: 1'b0};

    function automatic acp_cfg_t acp_sanitize(logic [DIV_W-1:0] d, logic o, logic m, logic c);
        acp_cfg_t r;
        r.mck_en = m;
        r.ch32   = c;
        if (d < DIV_W'(MIN_DIV)) begin
            r.div = DIV_W'(MIN_DIV);
            r.odd = 1'b0;
        end else begin
            r.div = d;
            r.odd = o;
        end
        return r;
    endfunction
endpackage

// File: rtl/acp_phase_gen.sv
module acp_phase_gen
    import acp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             odd,
    output logic             base_o,
    output logic             rise_evt,
    output logic             fall_evt
);
    phase_e          state_q, state_d;
    logic [PH_W-1:0] cnt_q, cnt_d;
    logic [PH_W-1:0] hi_len, lo_len;

    assign hi_len = {1'b0, div};
    assign lo_len = {1'b0, div} + PH_W'(odd);

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        rise_evt = 1'b0;
        fall_evt = 1'b0;
        if (!en) begin
            state_d = PH_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    state_d  = PH_HIGH;
                    cnt_d    = PH_W'(1);
                    rise_evt = 1'b1;
                end
                PH_HIGH: begin
                    if (cnt_q == hi_len) begin
                        state_d  = PH_LOW;
                        cnt_d    = PH_W'(1);
                        fall_evt = 1'b1;
                    end else begin
                        cnt_d = cnt_q + PH_W'(1);
                    end
                end
                PH_LOW: begin
                    if (cnt_q == lo_len) begin
                        state_d  = PH_HIGH;
                        cnt_d    = PH_W'(1);
                        rise_evt = 1'b1;
                    end else begin
                        cnt_d = cnt_q + PH_W'(1);
                    end
                end
                default: begin
                    state_d = PH_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb base_o = (state_q == PH_HIGH);

    // R2: a running phase never counts past its programmed length
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_IDLE) |-> (cnt_q >= PH_W'(1) && cnt_q <= lo_len));

    // R2: the high phase holds until DIV cycles have passed
    assert_high_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == PH_HIGH && cnt_q < hi_len) |=> base_o);
endmodule

// File: rtl/acp_bclk_gen.sv
module acp_bclk_gen
    import acp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mck_en,
    input  logic ch32,
    input  logic base,
    input  logic rise_evt,
    input  logic fall_evt,
    output logic mck_o,
    output logic bck_o,
    output logic bck_fall_evt
);
    bck_e            state_q, state_d;
    logic [RC_W-1:0] rc_q, rc_d;
    logic [RC_W-1:0] rc_last;

    assign rc_last = ch32 ? RC_W'(HALF_LONG - 1) : RC_W'(HALF_SHORT - 1);

    always_comb begin
        state_d      = state_q;
        rc_d         = rc_q;
        bck_fall_evt = 1'b0;
        if (!en) begin
            state_d = BK_OFF;
            rc_d    = '0;
        end else begin
            if (state_q != BK_OFF && state_q != BK_PASS && rise_evt)
                rc_d = (rc_q == rc_last) ? '0 : rc_q + RC_W'(1);
            unique case (state_q)
                BK_OFF: begin
                    if (!mck_en) begin
                        state_d = BK_PASS;
                    end else if (rise_evt) begin
                        state_d = BK_DIV_HI;
                        rc_d    = (rc_last == '0) ? '0 : RC_W'(1);
                    end
                end
                BK_PASS: bck_fall_evt = fall_evt;
                BK_DIV_HI: begin
                    if (rise_evt && rc_q == '0) begin
                        state_d      = BK_DIV_LO;
                        bck_fall_evt = 1'b1;
                    end
                end
                BK_DIV_LO: begin
                    if (rise_evt && rc_q == '0) state_d = BK_DIV_HI;
                end
                default: state_d = BK_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_OFF;
            rc_q    <= '0;
        end else begin
            state_q <= state_d;
            rc_q    <= rc_d;
        end
    end

    always_comb begin
        mck_o = (state_q == BK_DIV_HI || state_q == BK_DIV_LO) ? base : 1'b0;
        bck_o = (state_q == BK_PASS) ? base : (state_q == BK_DIV_HI);
    end

    // R4: no master clock toggles while it is switched off
    assert_mck_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mck_en |-> !mck_o);

    // R5: in master-clock mode the bit clock only moves on a master-clock rise or on disable
    assert_bck_on_mck_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && mck_en && !$stable(bck_o)) |-> $rose(mck_o));
endmodule

// File: rtl/acp_ws_gen.sv
module acp_ws_gen
    import acp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ch32,
    input  logic bck_fall_evt,
    output logic ws_o
);
    ws_e              state_q, state_d;
    logic [BIT_W-1:0] bit_q, bit_d;
    logic [BIT_W-1:0] bit_last;

    assign bit_last = ch32 ? BIT_W'(CH_LONG - 1) : BIT_W'(CH_SHORT - 1);

    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        if (!en) begin
            state_d = WS_LEFT;
            bit_d   = '0;
        end else if (bck_fall_evt) begin
            if (bit_q == bit_last) begin
                bit_d = '0;
                unique case (state_q)
                    WS_LEFT:  state_d = WS_RIGHT;
                    WS_RIGHT: state_d = WS_LEFT;
                    default:  state_d = WS_LEFT;
                endcase
            end else begin
                bit_d = bit_q + BIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_LEFT;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
        end
    end

    always_comb ws_o = (state_q == WS_RIGHT);

    // R7: bit counter never exceeds the selected channel length
    assert_bit_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= bit_last);
endmodule

// File: rtl/audio_clk_prescaler.sv
module audio_clk_prescaler
    import acp_pkg::*;
(
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_i,
    input  logic             odd_i,
    input  logic             mck_en_i,
    input  logic             ch32_i,
    output logic             mck_o,
    output logic             bck_o,
    output logic             ws_o
);
    acp_cfg_t cfg_q;
    logic     base, rise_evt, fall_evt, bck_fall_evt;

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n)       cfg_q <= CFG_RESET;
        else if (!enable) cfg_q <= acp_sanitize(div_i, odd_i, mck_en_i, ch32_i);
    end

    acp_phase_gen u_phase (
        .clk      (clk_src),
        .rst_n    (rst_n),
        .en       (enable),
        .div      (cfg_q.div),
        .odd      (cfg_q.odd),
        .base_o   (base),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    acp_bclk_gen u_bclk (
        .clk          (clk_src),
        .rst_n        (rst_n),
        .en           (enable),
        .mck_en       (cfg_q.mck_en),
        .ch32         (cfg_q.ch32),
        .base         (base),
        .rise_evt     (rise_evt),
        .fall_evt     (fall_evt),
        .mck_o        (mck_o),
        .bck_o        (bck_o),
        .bck_fall_evt (bck_fall_evt)
    );

    acp_ws_gen u_ws (
        .clk          (clk_src),
        .rst_n        (rst_n),
        .en           (enable),
        .ch32         (cfg_q.ch32),
        .bck_fall_evt (bck_fall_evt),
        .ws_o         (ws_o)
    );

    // R8: a low enable silences every output after the edge
    assert_idle_low_R8: assert property (@(posedge clk_src) disable iff (!rst_n)
        !enable |=> (!mck_o && !bck_o && !ws_o));

    // R9: the captured configuration is frozen while running
    assert_cfg_hold_R9: assert property (@(posedge clk_src) disable iff (!rst_n)
        enable |=> $stable(cfg_q));

    // R3: the divider in use is always legal
    assert_legal_div_R3: assert property (@(posedge clk_src) disable iff (!rst_n)
        cfg_q.div >= DIV_W'(MIN_DIV));

    // R7: word select changes only together with a bit-clock fall
    assert_ws_on_fall_R7: assert property (@(posedge clk_src) disable iff (!rst_n)
        ($past(enable) && !$stable(ws_o)) |-> $fell(bck_o));
endmodule

// File: tb/audio_clk_prescaler_tb.sv
`timescale 1ns/1ps
module audio_clk_prescaler_tb;
    logic       clk_src = 1'b0;
    logic       rst_n   = 1'b0;
    logic       enable  = 1'b0;
    logic [7:0] div_i   = 8'd0;
    logic       odd_i   = 1'b0;
    logic       mck_en_i = 1'b0;
    logic       ch32_i  = 1'b0;
    logic       mck_o, bck_o, ws_o;
    int         n_cmp = 0;
    int         n_bad = 0;

    always #10 clk_src = ~clk_src;

    audio_clk_prescaler u_dut (
        .clk_src  (clk_src),
        .rst_n    (rst_n),
        .enable   (enable),
        .div_i    (div_i),
        .odd_i    (odd_i),
        .mck_en_i (mck_en_i),
        .ch32_i   (ch32_i),
        .mck_o    (mck_o),
        .bck_o    (bck_o),
        .ws_o     (ws_o)
    );

    task automatic chk(string req, int k, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle=%0d actual=%0b expected=%0b", req, k, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic int eff_n(int d, int o);
        return (d < 2) ? 4 : 2 * d + o;
    endfunction

    // expected {mck, bck, ws} after the k-th edge of a run (k = 0 is the enabling edge)
    function automatic logic [2:0] model(int k, int d, int o, int m, int c);
        int ed, n, ch, half, p, f;
        logic base, mk, bk, w;
        ed   = (d < 2) ? 2 : d;
        n    = eff_n(d, o);
        ch   = c ? 32 : 16;
        half = c ? 2 : 4;
        p    = k / n;
        base = (k % n) < ed;
        if (m == 0) begin
            mk = 1'b0;
            bk = base;
            f  = (k >= ed) ? (k - ed) / n + 1 : 0;
        end else begin
            mk = base;
            bk = ((p / half) % 2) == 0;
            f  = ((p / half) + 1) / 2;
        end
        w = ((f / ch) % 2) == 1;
        return {mk, bk, w};
    endfunction

    task automatic run_cfg(int d, int o, int m, int c, int len, bit scramble);
        logic [2:0] e;
        string rq;
        @(negedge clk_src);
        enable   = 1'b0;
        div_i    = 8'(d);
        odd_i    = 1'(o);
        mck_en_i = 1'(m);
        ch32_i   = 1'(c);
        repeat (2) @(negedge clk_src);
        chk("R1 idle mck", -1, mck_o, 1'b0);
        chk("R1 idle bck", -1, bck_o, 1'b0);
        enable = 1'b1;
        for (int k = 0; k < len; k++) begin
            @(negedge clk_src);
            e  = model(k, d, o, m, c);
            rq = (d < 2) ? "R3" : ((k == 0) ? "R10" : "R2");
            chk({rq, " R4 mck"}, k, mck_o, e[2]);
            chk({rq, (m != 0) ? " R5 bck" : " R6 bck"}, k, bck_o, e[1]);
            chk({rq, " R7 ws"}, k, ws_o, e[0]);
            if (scramble && k == len / 3) begin
                // R9: garbage on config inputs while running
                div_i    = 8'(d + 7);
                odd_i    = ~odd_i;
                mck_en_i = ~mck_en_i;
                ch32_i   = ~ch32_i;
            end
        end
        enable = 1'b0;
        @(negedge clk_src);
        chk("R8 stop mck", len, mck_o, 1'b0);
        chk("R8 stop bck", len, bck_o, 1'b0);
        chk("R8 stop ws", len, ws_o, 1'b0);
    endtask

    initial begin
        repeat (180000) @(posedge clk_src);
        n_bad++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        report();
        $finish;
    end

    initial begin
        int dl[5] = '{0, 1, 2, 3, 5};
        repeat (3) @(negedge clk_src);
        // R1: reset state
        chk("R1 reset mck", -1, mck_o, 1'b0);
        chk("R1 reset bck", -1, bck_o, 1'b0);
        chk("R1 reset ws", -1, ws_o, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_src);
        chk("R1 post-reset bck", -1, bck_o, 1'b0);
        chk("R1 post-reset ws", -1, ws_o, 1'b0);

        // sweep: divider values incl. illegal ones (R3), odd, mode, channel length
        for (int di = 0; di < 5; di++) begin
            for (int o = 0; o < 2; o++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int c = 0; c < 2; c++) begin
                        int n, len;
                        n   = eff_n(dl[di], o);
                        len = (m != 0) ? 512 * n + 8 : (c != 0 ? 128 : 64) * n + 8;
                        run_cfg(dl[di], o, m, c, len,
                                (dl[di] == 3 && o == 1 && m == 1 && c == 0));
                    end
                end
            end
        end

        // R9: config change while running in pass-through mode
        run_cfg(4, 0, 0, 1, 128 * 8 + 8, 1'b1);
        // R8: stop mid-phase, then restart from the first phase
        run_cfg(4, 1, 0, 1, 30, 1'b0);
        run_cfg(4, 1, 0, 1, 100, 1'b0);
        // R2: large odd divider
        run_cfg(200, 1, 0, 0, 3 * 401, 1'b0);

        report();
        $finish;
    end
endmodule